// File: doc/BRIEF.md
# Four-Channel Converter Test Pattern Generator

This block stands between the sample outputs of a four-channel 12-bit converter and the capture logic that consumes them. Each channel either forwards its live sample or replaces it with a synthetic pattern. A receiver can then check its capture path against known values: a flat level, an alternating bit pattern, an incrementing count, a user-chosen word or a coarse sine wave. Every channel has its own 4-bit mode code, and the four codes sit as nibble pairs in two byte-wide configuration registers.

Software loads a register through a simple write port made of a strobe, a byte address and a data byte. Every output is a registered 12-bit unsigned value. It changes only on cycles where the sample-valid strobe is high, so the pattern steps at the converter's own sample rate. The pattern counters are per channel. Changing the code of one channel restarts that channel's sequence and leaves the other three running.

Top module: `tpg_quad`

## Requirements
- R1: A write to address 0x0A loads channel A's code from data bits 7:4 and channel B's code from bits 3:0. A write to address 0x0B loads channel C's code from bits 7:4 and channel D's code from bits 3:0. Writes to any other address change nothing. A new code governs the first valid sample accepted on a later clock edge.
- R2: While reset is asserted, and after it is released, every output reads 0 and every channel is in pass-through (code 0). This applies to a reset given in mid-run as well.
- R3: Code 0 forwards the channel's live sample. The unused codes 7, 8 and 10 to 15 behave the same way.
- R4: Code 1 outputs 0x000 and code 2 outputs 0xFFF.
- R5: Code 3 alternates 0xAAA and 0x555 on successive valid samples, starting with 0xAAA.
- R6: Code 4 outputs 0, 1, 2, ... and advances by exactly one on each valid sample. It wraps from 4095 to 0.
- R7: Code 5 outputs the value of the custom-pattern input. All channels in this mode share that value.
- R8: Code 6 (deskew) outputs the constant 0xAAA.
- R9: Code 9 repeats the unsigned sequence 0, 599, 2048, 3496, 4095, 3496, 2048, 599.
- R10: On a cycle where the sample-valid strobe is low, no output and no pattern counter changes.
- R11: A change of a channel's code restarts that channel's sequence at its first element. Other channels are unaffected, and rewriting the same code does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data (two 4-bit codes) |
| custom_pat | input | 12 | Custom pattern word shared by all channels |
| smp_valid | input | 1 | Sample-valid strobe; outputs advance only when high |
| live_in | input | 4x12 | Live samples, index 0 = channel A ... 3 = channel D |
| tp_out | output | 4x12 | Registered output samples, same channel order |

## Verification
A configuration write is registered on the edge where its strobe is high. Its code steers the sample accepted on the next edge. That sample's pattern value appears on the output just after that edge, so every result is due one edge after its valid strobe and two edges after the write that selected the mode. The bench therefore drives a write and a sample in separate cycles, changing inputs on falling edges. It reads each output on the falling edge after the sample's rising edge, when both the code register and the output register have settled. The hold and restart checks use the same cadence: stalled cycles, and rewrites of an unchanged code, are compared against the last value seen.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Per-channel mode codes
  typedef enum logic [3:0] {
    MODE_LIVE   = 4'd0,
    MODE_ZERO   = 4'd1,
    MODE_ONES   = 4'd2,
    MODE_TOGGLE = 4'd3,
    MODE_RAMP   = 4'd4,
    MODE_CUSTOM = 4'd5,
    MODE_DESKEW = 4'd6,
    MODE_SINE   = 4'd9
  } tpg_mode_e;

  localparam int CODE_W = 4;

  // Bits at odd positions set (0xAAA for 12 bits)
  function automatic logic [63:0] odd_bits(input int dw);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < dw && i < 64; i++) begin
      r[i] = (i % 2) == 1;
    end
    return r;
  endfunction

  // Eight-point unsigned sine, scaled to full range of dw bits
  function automatic int sine_point(input logic [2:0] idx, input int dw);
    int v;
    case (idx)
      3'd0:    v = 0;
      3'd1:    v = 599;
      3'd2:    v = 2048;
      3'd3:    v = 3496;
      3'd4:    v = 4095;
      3'd5:    v = 3496;
      3'd6:    v = 2048;
      default: v = 599;
    endcase
    return (v * ((1 << dw) - 1)) / 4095;
  endfunction

endpackage

// File: rtl/tpg_rst_sync.sv
module tpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/tpg_cfg_regs.sv
module tpg_cfg_regs #(
  parameter int                NCH      = 4,
  parameter int                AW       = 8,
  parameter logic [AW-1:0]     CFG_BASE = 8'h0A
) (
  input  logic                            clk,
  input  logic                            rst_s,
  input  logic                            wr_en,
  input  logic [AW-1:0]                   addr,
  input  logic [7:0]                      wdata,
  output logic [NCH-1:0][tpg_pkg::CODE_W-1:0] codes
);
  localparam int NREG = (NCH + 1) / 2;

  logic [NREG-1:0][7:0] regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    for (int r = 0; r < NREG; r++) begin
      if (wr_en && (addr == AW'(int'(CFG_BASE) + r))) regs_d[r] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  // Even channel in high nibble, odd channel in low nibble
  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    if (g % 2 == 0) begin : g_hi
      assign codes[g] = regs_q[g/2][7:4];
    end else begin : g_lo
      assign codes[g] = regs_q[g/2][3:0];
    end
  end
endmodule

// File: rtl/tpg_lane.sv
module tpg_lane #(
  parameter int DW = 12
) (
  input  logic                       clk,
  input  logic                       rst_s,
  input  logic [tpg_pkg::CODE_W-1:0] code,
  input  logic                       smp_valid,
  input  logic [DW-1:0]              live,
  input  logic [DW-1:0]              custom,
  output logic [DW-1:0]              sample
);
  import tpg_pkg::*;

  localparam logic [DW-1:0] PAT_ODD  = DW'(odd_bits(DW));
  localparam logic [DW-1:0] PAT_EVEN = ~PAT_ODD;

  logic [DW-1:0]     cnt_q, cnt_d, cnt_eff;
  logic [CODE_W-1:0] code_q, code_d;
  logic [DW-1:0]     out_q, out_d, pat;

  // Sequence restarts when the code differs from the one last used
  always_comb begin
    cnt_eff = (code != code_q) ? '0 : cnt_q;
    case (tpg_mode_e'(code))
      MODE_ZERO:   pat = '0;
      MODE_ONES:   pat = '1;
      MODE_TOGGLE: pat = cnt_eff[0] ? PAT_EVEN : PAT_ODD;
      MODE_RAMP:   pat = cnt_eff;
      MODE_CUSTOM: pat = custom;
      MODE_DESKEW: pat = PAT_ODD;
      MODE_SINE:   pat = DW'(sine_point(cnt_eff[2:0], DW));
      default:     pat = live;
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    code_d = code_q;
    out_d  = out_q;
    if (smp_valid) begin
      cnt_d  = cnt_eff + 1'b1;
      code_d = code;
      out_d  = pat;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q  <= '0;
      code_q <= '0;
      out_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      code_q <= code_d;
      out_q  <= out_d;
    end
  end

  assign sample = out_q;
endmodule

// File: rtl/tpg_quad.sv
module tpg_quad #(
  parameter int            DW       = 12,
  parameter int            NCH      = 4,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] CFG_BASE = 8'h0A
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr_en,
  input  logic [AW-1:0]          cfg_addr,
  input  logic [7:0]             cfg_wdata,
  input  logic [DW-1:0]          custom_pat,
  input  logic                   smp_valid,
  input  logic [NCH-1:0][DW-1:0] live_in,
  output logic [NCH-1:0][DW-1:0] tp_out
);
  logic                                rst_s;
  logic [NCH-1:0][tpg_pkg::CODE_W-1:0] mode_codes;

  tpg_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  tpg_cfg_regs #(.NCH(NCH), .AW(AW), .CFG_BASE(CFG_BASE)) u_cfg (
    .clk   (clk),
    .rst_s (rst_s),
    .wr_en (cfg_wr_en),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .codes (mode_codes)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    tpg_lane #(.DW(DW)) u_lane (
      .clk       (clk),
      .rst_s     (rst_s),
      .code      (mode_codes[g]),
      .smp_valid (smp_valid),
      .live      (live_in[g]),
      .custom    (custom_pat),
      .sample    (tp_out[g])
    );
  end
endmodule

// File: rtl/tpg_quad_chk.sv
module tpg_quad_chk #(
  parameter int            DW       = 12,
  parameter int            NCH      = 4,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] CFG_BASE = 8'h0A
) (
  input logic                   clk,
  input logic                   rst_s,
  input logic                   cfg_wr_en,
  input logic [AW-1:0]          cfg_addr,
  input logic [7:0]             cfg_wdata,
  input logic [DW-1:0]          custom_pat,
  input logic                   smp_valid,
  input logic [NCH-1:0][DW-1:0] live_in,
  input logic [NCH-1:0][3:0]    codes,
  input logic [NCH-1:0][DW-1:0] tp_out
);
  localparam logic [DW-1:0] ODD = DW'(tpg_pkg::odd_bits(DW));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] MY_ADDR = AW'(int'(CFG_BASE) + g / 2);

    if (g % 2 == 0) begin : g_hi
      p_cfg_load_r1: assert property (@(posedge clk) disable iff (!rst_s)
        (cfg_wr_en && cfg_addr == MY_ADDR) |=> codes[g] == $past(cfg_wdata[7:4]));
    end else begin : g_lo
      p_cfg_load_r1: assert property (@(posedge clk) disable iff (!rst_s)
        (cfg_wr_en && cfg_addr == MY_ADDR) |=> codes[g] == $past(cfg_wdata[3:0]));
    end

    p_cfg_keep_r1: assert property (@(posedge clk) disable iff (!rst_s)
      !(cfg_wr_en && cfg_addr == MY_ADDR) |=> $stable(codes[g]));

    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_s)
      (smp_valid && codes[g] == 4'd0) |=> tp_out[g] == $past(live_in[g]));

    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_s)
      (smp_valid && codes[g] == 4'd1) |=> tp_out[g] == '0);

    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_s)
      (smp_valid && codes[g] == 4'd3) |=> (tp_out[g] == ODD || tp_out[g] == ~ODD));

    p_ramp_step_r6: assert property (@(posedge clk) disable iff (!rst_s)
      (smp_valid && $past(smp_valid) && codes[g] == 4'd4 && $past(codes[g]) == 4'd4)
      |=> tp_out[g] == DW'($past(tp_out[g]) + 1'b1));

    p_custom_r7: assert property (@(posedge clk) disable iff (!rst_s)
      (smp_valid && codes[g] == 4'd5) |=> tp_out[g] == $past(custom_pat));

    p_deskew_r8: assert property (@(posedge clk) disable iff (!rst_s)
      (smp_valid && codes[g] == 4'd6) |=> tp_out[g] == ODD);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_s)
      !smp_valid |=> $stable(tp_out[g]));
  end
endmodule

bind tpg_quad tpg_quad_chk #(.DW(DW), .NCH(NCH), .AW(AW), .CFG_BASE(CFG_BASE)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .custom_pat (custom_pat),
  .smp_valid  (smp_valid),
  .live_in    (live_in),
  .codes      (mode_codes),
  .tp_out     (tp_out)
);

// File: tb/tpg_quad_test.sv
`timescale 1ns/1ps
module tpg_quad_test;
  localparam int DW  = 12;
  localparam int NCH = 4;
  localparam int NV  = 11;

  logic                   clk;
  logic                   rst_n;
  logic                   cfg_wr_en;
  logic [7:0]             cfg_addr;
  logic [7:0]             cfg_wdata;
  logic [DW-1:0]          custom_pat;
  logic                   smp_valid;
  logic [NCH-1:0][DW-1:0] live_in;
  logic [NCH-1:0][DW-1:0] tp_out;

  int  n_chk;
  int  n_fail;
  bit  done;

  tpg_quad uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .custom_pat (custom_pat),
    .smp_valid  (smp_valid),
    .live_in    (live_in),
    .tp_out     (tp_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {addr, data, live base, exp A, exp B, exp C, exp D}; live of channel n = base + n
  localparam logic [75:0] VEC [NV] = '{
    {8'h0A, 8'h12, 12'h100, 12'h000, 12'hFFF, 12'h102, 12'h103},
    {8'h0B, 8'h34, 12'h200, 12'h000, 12'hFFF, 12'hAAA, 12'h000},
    {8'hFF, 8'h00, 12'h300, 12'h000, 12'hFFF, 12'h555, 12'h001},
    {8'h0A, 8'h56, 12'h400, 12'h3C5, 12'hAAA, 12'hAAA, 12'h002},
    {8'h1A, 8'h99, 12'h500, 12'h3C5, 12'hAAA, 12'h555, 12'h003},
    {8'h0A, 8'h99, 12'h600, 12'h000, 12'h000, 12'hAAA, 12'h004},
    {8'hFF, 8'h00, 12'h700, 12'h257, 12'h257, 12'h555, 12'h005},
    {8'h0B, 8'h9F, 12'h7A0, 12'h800, 12'h800, 12'h000, 12'h7A3},
    {8'hFF, 8'h00, 12'h010, 12'hDA8, 12'hDA8, 12'h257, 12'h013},
    {8'h0A, 8'h78, 12'h020, 12'h020, 12'h021, 12'h800, 12'h023},
    {8'hFF, 8'h00, 12'h030, 12'h030, 12'h031, 12'hDA8, 12'h033}
  };

  localparam logic [DW-1:0] SINE [8] = '{12'd0, 12'd599, 12'd2048, 12'd3496,
                                          12'd4095, 12'd3496, 12'd2048, 12'd599};

  task automatic check(input string req, input int ch, input logic [DW-1:0] exp);
    n_chk++;
    if (tp_out[ch] !== exp) begin
      n_fail++;
      $display("FAIL %s ch%0d: actual %h expected %h", req, ch, tp_out[ch], exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // One valid sample; returns at the falling edge after it is registered
  task automatic sample(input logic [DW-1:0] base);
    for (int c = 0; c < NCH; c++) live_in[c] = base + DW'(c);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held [NCH];
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    custom_pat = 12'h3C5; smp_valid = 1'b0; live_in = '0;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R2 in reset", c, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R2 after release", c, '0);

    // Table walk: R1 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      cfg_write(VEC[i][75:68], VEC[i][67:60]);
      sample(VEC[i][59:48]);
      check("R1 R3 R4 R5 R6 R7 R8 R9 R11 table", 0, VEC[i][47:36]);
      check("R1 R3 R4 R5 R6 R7 R8 R9 R11 table", 1, VEC[i][35:24]);
      check("R1 R3 R4 R5 R6 R7 R8 R9 R11 table", 2, VEC[i][23:12]);
      check("R1 R3 R4 R5 R6 R7 R8 R9 R11 table", 3, VEC[i][11:0]);
    end

    // R10: stalled cycles change nothing
    for (int c = 0; c < NCH; c++) held[c] = tp_out[c];
    live_in = {NCH{12'hE0E}};
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R10 hold", c, held[c]);

    // R11: rewriting the same code keeps the sine running (C was at step 3)
    cfg_write(8'h0B, 8'h9F);
    sample(12'h040);
    check("R11 same code", 2, 12'd4095);
    check("R3 code F", 3, 12'h043);

    // R9: full sine cycle with wrap on A; B passes through
    cfg_write(8'h0A, 8'h90);
    for (int k = 0; k < 10; k++) begin
      sample(12'h050);
      check("R9 sine", 0, SINE[k % 8]);
      check("R3 live", 1, 12'h051);
    end

    // R6: ramp over full range and wrap on D
    cfg_write(8'h0B, 8'h04);
    for (int k = 0; k < 4098; k++) begin
      sample(12'h060);
      check("R6 ramp", 3, DW'(k));
    end
    check("R3 live C", 2, 12'h062);

    // R7: custom value shared and followed
    cfg_write(8'h0A, 8'h55);
    custom_pat = 12'hABC;
    sample(12'h070);
    check("R7 custom", 0, 12'hABC);
    check("R7 custom", 1, 12'hABC);
    custom_pat = 12'h123;
    sample(12'h070);
    check("R7 custom change", 0, 12'h123);
    check("R7 custom change", 1, 12'h123);

    // R2: mid-run reset returns to zeros and pass-through
    rst_n = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check("R2 mid reset", c, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sample(12'h080);
    for (int c = 0; c < NCH; c++) check("R2 pass after reset", c, 12'h080 + DW'(c));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule